// File: doc/BRIEF.md
# Collision Presence Generator with Heartbeat

This block drives the collision-presence line returned to the attached terminal equipment. It merges three causes onto one output: a collision level from an external comparator, a jabber-fault flag, and a self-test burst of its own. The block makes that burst after every transmission, and it is called the heartbeat. When at least one cause is active, the output carries a square wave at half the clock rate. With a 20 MHz clock this gives the 10 MHz signal the line expects. When no cause is active, the output rests low, which is the idle level.

The heartbeat starts when the synchronized transmit-activity level falls. The block then waits a programmable number of clock ticks before the burst and holds the burst for a second programmable number of ticks. The defaults of 22000 and 20000 ticks give about 1.1 ms and 1.0 ms at 20 MHz. A simulation can scale both down. If a new transmission starts before the delay has expired, the pending burst is dropped and timing restarts from the end of the new transmission. A heartbeat-enable input suppresses the self-test so that the block can sit on a repeater port. All four inputs are asynchronous and pass through a synchronizer before use.

Top module: `coll_presence_gen`

## Requirements
- R1: While reset is asserted, and on release, `cd_o` is low.
- R2: When `coll_det_i` is raised just after a rising clock edge, `cd_o` goes high after the third following rising edge. It then toggles on every edge while the input stays high.
- R3: `jab_act_i` drives `cd_o` with the same latency and waveform as `coll_det_i`.
- R4: With `hb_en_i` high, a fall of `tx_act_i` just after a rising edge makes the first heartbeat high appear after rising edge HB_DLY+4, counted from that fall.
- R5: The heartbeat burst lasts HB_LEN clock periods. For an even HB_LEN it gives HB_LEN/2 high pulses, and the last high pulse comes after edge HB_DLY+HB_LEN+2.
- R6: While `hb_en_i` is low, the end of a transmission produces no pulse on `cd_o`.
- R7: If `tx_act_i` rises again while the heartbeat delay is still running, that heartbeat is cancelled. The delay is then counted again from the next fall.
- R8: When no cause is active, `cd_o` stays low. From the third edge after the last cause is withdrawn, `cd_o` is low.
- R9: No runt pulse: each high level on `cd_o` lasts exactly one clock period and is followed by at least one low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, twice the output wave frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coll_det_i | input | 1 | Collision level from the external comparator (async) |
| jab_act_i | input | 1 | Jabber fault active (async) |
| tx_act_i | input | 1 | Transmit activity level (async) |
| hb_en_i | input | 1 | High enables the post-transmit heartbeat (async) |
| cd_o | output | 1 | Gated square wave to the collision line driver; low when idle |

## Verification
Several properties are checked on every cycle. Each high on `cd_o` lasts one cycle. The wave starts only from an active gate and then stops at low. A burst begins only after the full delay count and never counts past its width. A restart of transmit or a cleared enable removes any pending burst. Some behaviour is visible only in the bench's directed scenarios, observed at the output pin: the exact latency of the first pulse from each cause, the number of heartbeat pulses, the suppression with the enable low, and the re-armed timing after a retransmission.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [1:0] {HB_IDLE, HB_WAIT, HB_BURST} hb_st_e;

  typedef struct packed {
    logic coll;
    logic jab;
    logic tx;
    logic hb_en;
  } cpg_in_t;

  localparam int unsigned CPG_IN_W = $bits(cpg_in_t);
endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cpg_hb_timer.sv
module cpg_hb_timer
  import cpg_pkg::*;
#(
  parameter int unsigned HB_DLY = 22000,
  parameter int unsigned HB_LEN = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  input  logic en_i,
  output logic hb_o
);
  localparam int unsigned MAXC = (HB_DLY > HB_LEN) ? HB_DLY : HB_LEN;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(HB_DLY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(HB_LEN - 1);

  hb_st_e        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tx_q;
  logic          tx_fall;

  assign tx_fall = tx_q & ~tx_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      HB_IDLE: if (tx_fall && en_i) begin
        st_d  = HB_WAIT;
        cnt_d = '0;
      end
      HB_WAIT: begin
        if (!en_i || tx_i) begin
          st_d = HB_IDLE;   // retransmit or disable drops the pending burst
        end else if (cnt_q == DLY_LAST) begin
          st_d  = HB_BURST;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      HB_BURST: begin
        if (!en_i || cnt_q == LEN_LAST) st_d = HB_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = HB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HB_IDLE;
      cnt_q <= '0;
      tx_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tx_q  <= tx_i;
    end
  end

  assign hb_o = (st_q == HB_BURST);

  // R4
  burst_after_full_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hb_o) |-> ($past(st_q) == HB_WAIT && $past(cnt_q) == DLY_LAST));

  // R5
  burst_width_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_o |-> (cnt_q <= LEN_LAST));

  // R7
  retx_cancels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == HB_WAIT && tx_i) |=> !hb_o);

  // R6
  disabled_no_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hb_o);
endmodule

// File: rtl/cpg_wave.sv
module cpg_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic cd_o
);
  logic cd_q;

  // each high lasts one period; a closing gate always lands low, so no runt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cd_q <= 1'b0;
    else cd_q <= gate_i & ~cd_q;
  end

  assign cd_o = cd_q;

  // R9
  one_cycle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_q |=> !cd_q);

  // R8
  idle_stays_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !cd_q) |=> !cd_q);

  // R2
  start_needs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cd_q) |-> $past(gate_i));
endmodule

// File: rtl/coll_presence_gen.sv
module coll_presence_gen
  import cpg_pkg::*;
#(
  parameter int unsigned HB_DLY      = 22000,
  parameter int unsigned HB_LEN      = 20000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coll_det_i,
  input  logic jab_act_i,
  input  logic tx_act_i,
  input  logic hb_en_i,
  output logic cd_o
);
  cpg_in_t raw, syn;
  logic    hb;
  logic    gate;

  assign raw = '{coll: coll_det_i, jab: jab_act_i, tx: tx_act_i, hb_en: hb_en_i};

  cpg_sync #(.W(CPG_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  cpg_hb_timer #(.HB_DLY(HB_DLY), .HB_LEN(HB_LEN)) u_hb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tx_i  (syn.tx),
    .en_i  (syn.hb_en),
    .hb_o  (hb)
  );

  assign gate = syn.coll | syn.jab | hb;

  cpg_wave u_wave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(gate),
    .cd_o  (cd_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !cd_o);
endmodule

// File: tb/sim_coll_presence_gen.sv
module sim_coll_presence_gen;
  localparam int D = 20;
  localparam int L = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic coll_det_i = 1'b0, jab_act_i = 1'b0, tx_act_i = 1'b0, hb_en_i = 1'b1;
  logic cd_o;

  int nvec = 0, nerr = 0;
  int first_hi, last_hi, n_hi, n_runt;
  bit done = 0;

  always #4 clk = ~clk;

  coll_presence_gen #(.HB_DLY(D), .HB_LEN(L)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .coll_det_i(coll_det_i), .jab_act_i(jab_act_i),
    .tx_act_i(tx_act_i), .hb_en_i(hb_en_i), .cd_o(cd_o)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // sample n cycles, each at the falling edge after rising edge i
  task automatic observe(input int n);
    logic prev = 1'b0;
    first_hi = 0; last_hi = 0; n_hi = 0; n_runt = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (cd_o) begin
        if (first_hi == 0) first_hi = i;
        last_hi = i;
        n_hi++;
        if (prev) n_runt++;
      end
      prev = cd_o;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 cd_o in reset", int'(cd_o), 0);
    rst_ni = 1'b1;
    observe(30);
    check("R8 idle highs", n_hi, 0);
  endtask

  task automatic t_cause(input bit jab);
    string rq;
    rq = jab ? "R3" : "R2";
    if (jab) jab_act_i = 1'b1; else coll_det_i = 1'b1;
    observe(20);
    check({rq, " first high"}, first_hi, 3);
    check({rq, " high count"}, n_hi, 9);
    check("R9 runt count", n_runt, 0);
    jab_act_i = 1'b0; coll_det_i = 1'b0;
    observe(12);
    check("R8 release last high", last_hi, 1);
    check("R8 release highs", n_hi, 1);
  endtask

  task automatic t_heartbeat();
    tx_act_i = 1'b1;
    observe(6);
    check("R8 during tx", n_hi, 0);
    tx_act_i = 1'b0;
    observe(D + L + 14);
    check("R4 heartbeat first high", first_hi, D + 4);
    check("R5 heartbeat highs", n_hi, L / 2);
    check("R5 heartbeat last high", last_hi, D + L + 2);
    check("R9 heartbeat runt", n_runt, 0);
  endtask

  task automatic t_disabled();
    hb_en_i = 1'b0;
    observe(5);
    tx_act_i = 1'b1;
    observe(6);
    tx_act_i = 1'b0;
    observe(D + L + 14);
    check("R6 disabled highs", n_hi, 0);
    hb_en_i = 1'b1;
    observe(5);
  endtask

  task automatic t_retrig();
    tx_act_i = 1'b1;
    observe(6);
    tx_act_i = 1'b0;
    observe(10);
    check("R7 early highs", n_hi, 0);
    tx_act_i = 1'b1;
    observe(D + 10);
    check("R7 cancelled highs", n_hi, 0);
    tx_act_i = 1'b0;
    observe(D + L + 14);
    check("R7 rearmed first high", first_hi, D + 4);
    check("R7 rearmed highs", n_hi, L / 2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cause(1'b0);
    t_cause(1'b1);
    t_heartbeat();
    t_disabled();
    t_retrig();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule